// File: doc/BRIEF.md
# Drive Command and Sense Sequencer

This block sits between a floppy controller's command logic and the drive cable. The drive decodes a 4-bit code: three phase address lines carry bits 2:0 and a separate select line carries bit 3. The same code means one of two things. It names a command that the drive latches on a strobe pulse, or it names a status bit that the drive presents on one shared sense line. The requester gives a code and a flag for action or sense. It waits while `busy` is high and collects the result when `done` pulses.

Each access starts with the phase lines on the neutral code 3, and the select line changes only while they sit there. The block then applies the code and holds it for a settle time. An action follows with a strobe pulse and a trailing hold. A sense read samples the sense line, where a low level means logic 1. When the access ends, the phase lines go back to the neutral code. All durations are counted in microseconds, taken from a cycle-based tick whose period is a parameter. Typical actions are step (1), motor on (2), motor off (6), eject (7), seek outward (0), seek inward (4), MFM mode (9) and GCR mode (13). Typical sense codes are disk in (8), write protect (9), track zero (10), seek complete (14) and drive present (7).

Top module: `drive_cmd_seq`

## Requirements
- R1: After reset the phase lines read 3, and select, strobe, busy, done and sense_bit are all 0.
- R2: A request accepted in idle is followed by one busy cycle in which the phase lines read 3 and the select line takes bit 3 of the code. The select line then keeps that value until the next accepted request, and it never changes while the phase lines differ from 3.
- R3: After the park cycle the phase lines carry bits 2:0 of the code for HOLD_US microseconds. That is HOLD_US*CLK_PER_US cycles.
- R4: For an action (req_act=1), the strobe is high for exactly STROBE_US microseconds right after the hold. The code then stays applied for TAIL_US more microseconds with the strobe low.
- R5: Every access ends with a single-cycle `done` in which the phase lines are back at 3. `busy` is high from the cycle after acceptance through the `done` cycle, and it is low in the cycle after `done`.
- R6: For a sense read (req_act=0), the sense line is sampled on the last cycle of the hold, and `sense_bit` becomes its inverse when `done` is high. `sense_bit` keeps its value through later actions until the next sense read.
- R7: The strobe is never high during a sense read.
- R8: A request raised while busy is ignored. The running access completes with its own code and timing, and no new access starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_code | input | 4 | Drive code: bit 3 to select, bits 2:0 to phase lines |
| req_act | input | 1 | 1 = latch as action with strobe, 0 = sense read |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| sense_bit | output | 1 | Last sensed value (inverse of the sense line) |
| drv_phase | output | 3 | Phase address lines to the drive |
| drv_select | output | 1 | Select line to the drive |
| drv_strobe | output | 1 | Latch strobe to the drive |
| drv_sense | input | 1 | Shared sense line from the drive, low means 1 |

## Verification
The directed pass steps through every listed action code and every listed sense code. It covers codes whose bits 2:0 equal the neutral value, where the phase lines never move, and codes that differ only in bit 3, which the select line alone tells apart. Random requests mix actions and sense reads with random sense levels, so the strobe window, the sense inversion and the retention of `sense_bit` across actions are each checked against both outcomes. Some accesses get a conflicting request while busy. That case separates a sequencer that ignores the intruder from one that latches its code or restarts after `done`.

// File: rtl/drv_seq_pkg.sv
package drv_seq_pkg;

    localparam logic [2:0] NEUTRAL_PHASE = 3'd3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PARK,
        SQ_HOLD,
        SQ_PULSE,
        SQ_TAIL,
        SQ_FIN
    } seq_state_t;

    typedef struct packed {
        logic [3:0] code;
        logic       act;
    } drv_req_t;

    function automatic logic [2:0] phase_bits(input logic [3:0] c);
        return c[2:0];
    endfunction

    function automatic logic select_bit(input logic [3:0] c);
        return c[3];
    endfunction

    function automatic bit timed_state(input seq_state_t s);
        return (s == SQ_HOLD) || (s == SQ_PULSE) || (s == SQ_TAIL);
    endfunction

endpackage

// File: rtl/drv_us_tick.sv
module drv_us_tick #(
    parameter int CLK_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] cnt;

    assign tick = !clear && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_tick_period_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick || (CLK_PER_US == 1));
endmodule

// File: rtl/drv_sense_cap.sv
module drv_sense_cap (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic line,
    output logic bit_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_out <= 1'b0;
        end else if (sample) begin
            bit_out <= ~line;
        end
    end

    assert_sense_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(bit_out));
endmodule

// File: rtl/drv_sequencer.sv
module drv_sequencer
    import drv_seq_pkg::*;
#(
    parameter int HOLD_US   = 1,
    parameter int STROBE_US = 2,
    parameter int TAIL_US   = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  drv_req_t   req,
    input  logic       tick,
    output logic       tmr_clear,
    output logic       sample_now,
    output logic       busy,
    output logic       done,
    output logic [2:0] phase,
    output logic       sel,
    output logic       strobe
);
    localparam int MAX_US = (HOLD_US > STROBE_US) ?
                            ((HOLD_US > TAIL_US) ? HOLD_US : TAIL_US) :
                            ((STROBE_US > TAIL_US) ? STROBE_US : TAIL_US);
    localparam int UW = $clog2(MAX_US + 1);
    localparam logic [UW-1:0] HOLD_LAST  = UW'(HOLD_US - 1);
    localparam logic [UW-1:0] PULSE_LAST = UW'(STROBE_US - 1);
    localparam logic [UW-1:0] TAIL_LAST  = UW'(TAIL_US - 1);

    seq_state_t    state;
    drv_req_t      cur;
    logic [UW-1:0] us_cnt;
    logic [UW-1:0] seg_last;
    logic          seg_end;
    logic [2:0]    phase_q;
    logic          sel_q;
    logic          strobe_q;

    always_comb begin
        case (state)
            SQ_HOLD:  seg_last = HOLD_LAST;
            SQ_PULSE: seg_last = PULSE_LAST;
            default:  seg_last = TAIL_LAST;
        endcase
    end

    assign seg_end    = timed_state(state) && tick && (us_cnt == seg_last);
    assign tmr_clear  = !timed_state(state);
    assign sample_now = (state == SQ_HOLD) && seg_end && !cur.act;
    assign busy       = (state != SQ_IDLE);
    assign done       = (state == SQ_FIN);
    assign phase      = phase_q;
    assign sel        = sel_q;
    assign strobe     = strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cur      <= '0;
            us_cnt   <= '0;
            phase_q  <= NEUTRAL_PHASE;
            sel_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            if (timed_state(state) && tick) begin
                us_cnt <= seg_end ? '0 : us_cnt + 1'b1;
            end
            case (state)
                SQ_IDLE: begin
                    if (req_valid) begin
                        cur     <= req;
                        phase_q <= NEUTRAL_PHASE;
                        sel_q   <= select_bit(req.code);
                        state   <= SQ_PARK;
                    end
                end
                SQ_PARK: begin
                    phase_q <= phase_bits(cur.code);
                    us_cnt  <= '0;
                    state   <= SQ_HOLD;
                end
                SQ_HOLD: begin
                    if (seg_end) begin
                        if (cur.act) begin
                            strobe_q <= 1'b1;
                            state    <= SQ_PULSE;
                        end else begin
                            phase_q <= NEUTRAL_PHASE;
                            state   <= SQ_FIN;
                        end
                    end
                end
                SQ_PULSE: begin
                    if (seg_end) begin
                        strobe_q <= 1'b0;
                        state    <= SQ_TAIL;
                    end
                end
                SQ_TAIL: begin
                    if (seg_end) begin
                        phase_q <= NEUTRAL_PHASE;
                        state   <= SQ_FIN;
                    end
                end
                SQ_FIN: begin
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assert_sel_while_parked_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q) |-> (phase_q == NEUTRAL_PHASE && $past(phase_q) == NEUTRAL_PHASE));

    assert_leave_park_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q != NEUTRAL_PHASE && $past(phase_q) == NEUTRAL_PHASE) |-> $past(state) == SQ_PARK);

    assert_strobe_code_stable_R4: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> $stable(phase_q));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    assert_done_parked_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> phase_q == NEUTRAL_PHASE);

    assert_no_strobe_sense_R7: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> cur.act);

    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(cur));
endmodule

// File: rtl/drive_cmd_seq.sv
module drive_cmd_seq
    import drv_seq_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int HOLD_US    = 1,
    parameter int STROBE_US  = 2,
    parameter int TAIL_US    = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [3:0] req_code,
    input  logic       req_act,
    output logic       busy,
    output logic       done,
    output logic       sense_bit,
    output logic [2:0] drv_phase,
    output logic       drv_select,
    output logic       drv_strobe,
    input  logic       drv_sense
);
    drv_req_t req;
    logic     tick;
    logic     tmr_clear;
    logic     sample_now;

    assign req.code = req_code;
    assign req.act  = req_act;

    drv_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clear),
        .tick  (tick)
    );

    drv_sequencer #(
        .HOLD_US   (HOLD_US),
        .STROBE_US (STROBE_US),
        .TAIL_US   (TAIL_US)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req        (req),
        .tick       (tick),
        .tmr_clear  (tmr_clear),
        .sample_now (sample_now),
        .busy       (busy),
        .done       (done),
        .phase      (drv_phase),
        .sel        (drv_select),
        .strobe     (drv_strobe)
    );

    drv_sense_cap u_sense (
        .clk     (clk),
        .rst     (rst),
        .sample  (sample_now),
        .line    (drv_sense),
        .bit_out (sense_bit)
    );
endmodule

// File: tb/drive_cmd_seq_test.sv
`timescale 1ns/1ps
module drive_cmd_seq_test;
    localparam int C  = 100;
    localparam int H  = 1 * C;
    localparam int S  = 2 * C;
    localparam int T  = 1 * C;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_code = 4'd0;
    logic       req_act = 1'b0;
    logic       busy, done, sense_bit, drv_select, drv_strobe;
    logic [2:0] drv_phase;
    logic       drv_sense = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit exp_sense = 1'b0;
    bit exp_sel   = 1'b0;

    always #5 clk = ~clk;

    drive_cmd_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
        .req_act(req_act), .busy(busy), .done(done), .sense_bit(sense_bit),
        .drv_phase(drv_phase), .drv_select(drv_select), .drv_strobe(drv_strobe),
        .drv_sense(drv_sense)
    );

    task automatic chk(input bit ok, input string tag, input int actv, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actv, expv, $time);
        end
    endtask

    function automatic int end_k(input bit act);
        return act ? (2 + H + S + T) : (2 + H);
    endfunction

    function automatic int exp_phase(input int k, input logic [3:0] code, input bit act);
        if (k >= 2 && k < end_k(act)) return int'(code[2:0]);
        return 3;
    endfunction

    function automatic bit exp_strobe(input int k, input bit act);
        return act && (k >= 2 + H) && (k < 2 + H + S);
    endfunction

    task automatic run_op(input logic [3:0] code, input bit act, input bit line, input bit intrude);
        int last;
        last = end_k(act);
        @(negedge clk);
        req_valid = 1'b1; req_code = code; req_act = act; drv_sense = line;
        exp_sel = code[3];
        for (int k = 1; k <= last + 3; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req_valid = 1'b0;
                chk(drv_phase == 3, "R2 park phase", drv_phase, 3);
            end
            if (intrude && k == 3) begin
                req_valid = 1'b1; req_code = ~code; req_act = ~act;
            end
            if (intrude && k == 4) req_valid = 1'b0;
            if (k == last && !act) exp_sense = ~line;
            chk(drv_select == exp_sel, "R2 select", drv_select, exp_sel);
            if (k > 1)
                chk(int'(drv_phase) == exp_phase(k, code, act), act ? "R3/R4 phase" : "R3 phase",
                    drv_phase, exp_phase(k, code, act));
            if (act)
                chk(drv_strobe == exp_strobe(k, act), "R4 strobe", drv_strobe, exp_strobe(k, act));
            else
                chk(drv_strobe == 1'b0, "R7 strobe in sense", drv_strobe, 0);
            chk(done == (k == last), "R5 done", done, k == last);
            chk(busy == (k <= last), intrude ? "R8 busy" : "R5 busy", busy, k <= last);
            chk(sense_bit == exp_sense, "R6 sense_bit", sense_bit, exp_sense);
        end
    endtask

    initial begin
        static int act_codes[8]    = '{0, 4, 1, 2, 6, 7, 9, 13};
        static int sense_codes[11] = '{0, 1, 2, 4, 12, 7, 8, 9, 10, 11, 14};
        void'($urandom(32'h5eed_0c41));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(drv_phase == 3, "R1 phase", drv_phase, 3);
        chk(drv_select == 0, "R1 select", drv_select, 0);
        chk(drv_strobe == 0, "R1 strobe", drv_strobe, 0);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(sense_bit == 0, "R1 sense_bit", sense_bit, 0);
        rst = 1'b0;
        foreach (act_codes[i]) run_op(4'(act_codes[i]), 1'b1, 1'b0, i == 2);
        foreach (sense_codes[i]) run_op(4'(sense_codes[i]), 1'b0, i[0], i == 5);
        run_op(4'd6, 1'b1, 1'b1, 1'b0);
        for (int n = 0; n < 30; n++) begin
            run_op(4'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule